// File: doc/BRIEF.md
# Display Memory Cycle Sequencer

This block turns single-byte access requests from inside a display controller into bus cycles on an external byte-wide asynchronous SRAM that holds the video image. Every access, read or write, occupies exactly three system clocks. In the first clock the address and direction are placed on the bus while the active-low chip enable stays high. In the next two clocks chip enable is low. Write data comes from a register loaded when the request is accepted. Read data is captured at the clock edge that ends the strobe.

Requests arrive on a valid/acknowledge port carrying a 16-bit address, a direction bit and a write byte. The acknowledge is given only when the sequencer is idle or in the final clock of a cycle. A request that is waiting when a cycle ends therefore starts the next cycle with no idle clock between them. The bidirectional data bus is presented as separate output data, output enable and input data, so that the pad ring can build the tristate buffer.

Top module: `vmem_cycle_seq`

## Requirements
- R1: `mem_addr` carries the full 16-bit address of the accepted request. It is valid from the first clock of the cycle and does not change while `mem_ce_n` is low.
- R2: A read cycle lasts exactly three clocks, measured from the edge that accepts it to the edge that ends it.
- R3: A write cycle lasts exactly three clocks, measured the same way.
- R4: In every cycle `mem_ce_n` is high (1) for the first clock and low (0) for the second and third clocks. It stays high while idle.
- R5: `mem_rw` is 1 for a read and 0 for a write, and is already at that value in the clock before `mem_ce_n` falls. While idle it is 1.
- R6: During a write strobe, `mem_wdata` equals the byte presented with the request, taken from a register, and stays constant through both low clocks.
- R7: For a read, `mem_rdata` is captured at the edge that ends the second low clock. In the clock after that edge, `rd_valid` is 1 for exactly one clock and `rd_data` holds the captured byte.
- R8: `mem_wdata_oe` is 1 only in the two low clocks of a write cycle, and 0 at all other times.
- R9: `req_ack` equals `req_valid` while the sequencer is idle or in the last clock of a cycle, and is 0 otherwise. An acknowledged request starts its setup clock right after that edge, so back-to-back requests leave no idle clock.
- R10: An active-low asynchronous reset returns the block to idle at once, even in the middle of a cycle: `mem_ce_n`=1, `mem_rw`=1, `mem_wdata_oe`=0, `rd_valid`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | An access request is presented |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 16 | Byte address of the request |
| req_wdata | input | 8 | Byte to write |
| req_ack | output | 1 | Request accepted at the next edge |
| rd_valid | output | 1 | One-clock pulse: rd_data holds read result |
| rd_data | output | 8 | Byte returned by the last read |
| mem_addr | output | 16 | SRAM address bus |
| mem_ce_n | output | 1 | SRAM chip enable, active low |
| mem_rw | output | 1 | SRAM direction: 1 read, 0 write |
| mem_wdata | output | 8 | Data driven toward the SRAM |
| mem_wdata_oe | output | 1 | Enable for the data bus output buffer |
| mem_rdata | input | 8 | Data received from the SRAM |

## Verification
The embedded properties check the shape of the strobe on every clock: it is low for exactly two clocks and then rises. They also check that direction and address are stable around the strobe, that the output enable is confined to write strobes, that write data does not move while driven, and that read results come out as one-clock pulses. Only the bench scenarios can show that the right values travel end to end. Its memory model returns data only after a full clock of strobe, so an early capture reads the wrong byte. Those scenarios also cover exact three-clock spacing under back-to-back traffic and recovery from a reset that cuts a write short.

// File: rtl/vmc_pkg.sv
package vmc_pkg;
  // Phase of a memory cycle; the order is the strobe sequence.
  typedef enum logic [1:0] {
    PH_SETUP = 2'd0,
    PH_STB_A = 2'd1,
    PH_STB_B = 2'd2
  } vmc_phase_e;

  function automatic logic ph_is_strobe(vmc_phase_e ph);
    return (ph == PH_STB_A) || (ph == PH_STB_B);
  endfunction

  function automatic logic ph_is_last(vmc_phase_e ph);
    return ph == PH_STB_B;
  endfunction

  function automatic vmc_phase_e ph_next(vmc_phase_e ph);
    case (ph)
      PH_SETUP: return PH_STB_A;
      PH_STB_A: return PH_STB_B;
      default:  return PH_SETUP;
    endcase
  endfunction
endpackage

// File: rtl/vmc_phase_ctrl.sv
module vmc_phase_ctrl
  import vmc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  output logic       busy,
  output vmc_phase_e phase,
  output logic       at_boundary,
  output logic       strobe_on,
  output logic       cycle_end
);
  assign at_boundary = !busy || ph_is_last(phase);
  assign strobe_on   = busy && ph_is_strobe(phase);
  assign cycle_end   = busy && ph_is_last(phase);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy  <= 1'b0;
      phase <= PH_SETUP;
    end else if (start) begin
      busy  <= 1'b1;
      phase <= PH_SETUP;
    end else if (busy) begin
      if (ph_is_last(phase)) busy <= 1'b0;
      phase <= ph_next(phase);
    end
  end

  AST_START_SETUP: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (busy && phase == PH_SETUP && !strobe_on)) else $error("start"); // R9
  AST_NO_EARLY_START: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && phase == PH_SETUP) |=> (busy && phase == PH_STB_A)) else $error("early"); // R2
endmodule

// File: rtl/vmc_req_latch.sv
module vmc_req_latch #(
  parameter int AW = 16,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic          in_write,
  input  logic [AW-1:0] in_addr,
  input  logic [DW-1:0] in_wdata,
  output logic          q_write,
  output logic [AW-1:0] q_addr,
  output logic [DW-1:0] q_wdata
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_write <= 1'b0;
      q_addr  <= '0;
      q_wdata <= '0;
    end else if (load) begin
      q_write <= in_write;
      q_addr  <= in_addr;
      q_wdata <= in_wdata;
    end
  end
endmodule

// File: rtl/vmc_bus_drv.sv
module vmc_bus_drv #(
  parameter int AW = 16,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          busy,
  input  logic          strobe_on,
  input  logic          q_write,
  input  logic [AW-1:0] q_addr,
  input  logic [DW-1:0] q_wdata,
  output logic [AW-1:0] mem_addr,
  output logic          mem_ce_n,
  output logic          mem_rw,
  output logic [DW-1:0] mem_wdata,
  output logic          mem_wdata_oe
);
  assign mem_addr     = q_addr;
  assign mem_ce_n     = !strobe_on;
  assign mem_rw       = !(busy && q_write);
  assign mem_wdata    = q_wdata;
  assign mem_wdata_oe = strobe_on && q_write;

  AST_CE_LOW_TWO: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mem_ce_n) |=> !mem_ce_n) else $error("ce short"); // R4
  AST_CE_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_ce_n && $past(!mem_ce_n)) |=> mem_ce_n) else $error("ce long"); // R4
  AST_RW_SETUP: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mem_ce_n) |-> $stable(mem_rw)) else $error("rw setup"); // R5
  AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_ce_n && $past(!mem_ce_n)) |-> $stable(mem_addr)) else $error("addr"); // R1
  AST_OE_WRITE_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wdata_oe |-> (!mem_ce_n && !mem_rw)) else $error("oe"); // R8
  AST_WDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_wdata_oe && $past(mem_wdata_oe)) |-> $stable(mem_wdata)) else $error("wdata"); // R6
endmodule

// File: rtl/vmc_rd_capture.sv
module vmc_rd_capture #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cycle_end,
  input  logic          q_write,
  input  logic          mem_ce_n,
  input  logic          mem_rw,
  input  logic [DW-1:0] mem_rdata,
  output logic          rd_valid,
  output logic [DW-1:0] rd_data
);
  logic take_read;
  assign take_read = cycle_end && !q_write;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= take_read;
      if (take_read) rd_data <= mem_rdata;
    end
  end

  AST_RD_AFTER_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    take_read |-> (!mem_ce_n && mem_rw && $past(!mem_ce_n))) else $error("rd when"); // R7
  AST_RD_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |=> !rd_valid) else $error("rd pulse"); // R7
endmodule

// File: rtl/vmem_cycle_seq.sv
module vmem_cycle_seq
  import vmc_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic          req_write,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  output logic          req_ack,
  output logic          rd_valid,
  output logic [DW-1:0] rd_data,
  output logic [AW-1:0] mem_addr,
  output logic          mem_ce_n,
  output logic          mem_rw,
  output logic [DW-1:0] mem_wdata,
  output logic          mem_wdata_oe,
  input  logic [DW-1:0] mem_rdata
);
  logic          busy, at_boundary, strobe_on, cycle_end, q_write;
  vmc_phase_e    phase;
  logic [AW-1:0] q_addr;
  logic [DW-1:0] q_wdata;

  assign req_ack = req_valid && at_boundary;

  vmc_phase_ctrl u_phase (
    .clk(clk), .rst_n(rst_n), .start(req_ack), .busy(busy), .phase(phase),
    .at_boundary(at_boundary), .strobe_on(strobe_on), .cycle_end(cycle_end)
  );

  vmc_req_latch #(.AW(AW), .DW(DW)) u_latch (
    .clk(clk), .rst_n(rst_n), .load(req_ack), .in_write(req_write),
    .in_addr(req_addr), .in_wdata(req_wdata),
    .q_write(q_write), .q_addr(q_addr), .q_wdata(q_wdata)
  );

  vmc_bus_drv #(.AW(AW), .DW(DW)) u_bus (
    .clk(clk), .rst_n(rst_n), .busy(busy), .strobe_on(strobe_on),
    .q_write(q_write), .q_addr(q_addr), .q_wdata(q_wdata),
    .mem_addr(mem_addr), .mem_ce_n(mem_ce_n), .mem_rw(mem_rw),
    .mem_wdata(mem_wdata), .mem_wdata_oe(mem_wdata_oe)
  );

  vmc_rd_capture #(.DW(DW)) u_rd (
    .clk(clk), .rst_n(rst_n), .cycle_end(cycle_end), .q_write(q_write),
    .mem_ce_n(mem_ce_n), .mem_rw(mem_rw), .mem_rdata(mem_rdata),
    .rd_valid(rd_valid), .rd_data(rd_data)
  );

  AST_ACK_THEN_SETUP: assert property (@(posedge clk) disable iff (!rst_n)
    req_ack |=> mem_ce_n) else $error("ack"); // R9
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (mem_ce_n && mem_rw && !mem_wdata_oe)) else $error("idle"); // R10
endmodule

// File: tb/sim_vmem_cycle_seq.sv
module sim_vmem_cycle_seq;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid, req_write;
  logic [15:0] req_addr;
  logic [7:0]  req_wdata;
  logic        req_ack, rd_valid, mem_ce_n, mem_rw, mem_wdata_oe;
  logic [7:0]  rd_data, mem_wdata, mem_rdata;
  logic [15:0] mem_addr;

  always #10 clk = ~clk; // 50 MHz

  vmem_cycle_seq u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_ack(req_ack),
    .rd_valid(rd_valid), .rd_data(rd_data), .mem_addr(mem_addr),
    .mem_ce_n(mem_ce_n), .mem_rw(mem_rw), .mem_wdata(mem_wdata),
    .mem_wdata_oe(mem_wdata_oe), .mem_rdata(mem_rdata)
  );

  int checks = 0;
  int errors = 0;
  bit done = 0;

  function automatic logic [7:0] seed_byte(int i);
    return 8'((i * 37 + 11) ^ (i >> 3));
  endfunction

  // SRAM model: data appears only after one full clock of strobe.
  logic [7:0] sram [256];
  logic [7:0] ref_mem [256];
  int lowcnt;
  initial for (int i = 0; i < 256; i++) begin
    sram[i] = seed_byte(i);
    ref_mem[i] = seed_byte(i);
  end
  assign mem_rdata = (!mem_ce_n && mem_rw && lowcnt != 0) ? sram[mem_addr[7:0]] : 8'hC3;
  always @(posedge clk) begin
    if (!rst_n || mem_ce_n) lowcnt <= 0;
    else lowcnt <= lowcnt + 1;
    if (rst_n && !mem_ce_n && !mem_rw && mem_wdata_oe) sram[mem_addr[7:0]] <= mem_wdata;
  end

  task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", req, act, exp, $time);
    end
  endtask

  // Expected-timeline model, advanced once per clock at the falling edge.
  int         ph = -1;
  bit         cur_wr, rd_pend;
  logic [15:0] cur_addr;
  logic [7:0]  cur_data, rd_exp, cur_rd;
  int         since;

  always @(negedge clk) begin
    if (!rst_n) begin
      chk(mem_ce_n == 1'b1, "R10 ce_n", 32'(mem_ce_n), 1);
      chk(mem_rw == 1'b1, "R10 rw", 32'(mem_rw), 1);
      chk(mem_wdata_oe == 1'b0, "R10 oe", 32'(mem_wdata_oe), 0);
      chk(rd_valid == 1'b0, "R10 rd_valid", 32'(rd_valid), 0);
      ph = -1; rd_pend = 0; since = 0;
    end else begin
      bit strobe, take;
      strobe = (ph == 1 || ph == 2);
      chk(mem_ce_n == !strobe, "R4 ce_n shape", 32'(mem_ce_n), 32'(!strobe));
      chk(mem_rw == !(ph >= 0 && cur_wr), "R5 rw", 32'(mem_rw), 32'(!(ph >= 0 && cur_wr)));
      if (ph >= 0) chk(mem_addr == cur_addr, "R1 addr", 32'(mem_addr), 32'(cur_addr));
      chk(mem_wdata_oe == (strobe && cur_wr), "R8 oe", 32'(mem_wdata_oe), 32'(strobe && cur_wr));
      if (strobe && cur_wr) chk(mem_wdata == cur_data, "R6 wdata", 32'(mem_wdata), 32'(cur_data));
      chk(rd_valid == rd_pend, "R7 rd_valid", 32'(rd_valid), 32'(rd_pend));
      if (rd_pend) chk(rd_data == rd_exp, "R7 rd_data", 32'(rd_data), 32'(rd_exp));
      chk(req_ack == (req_valid && (ph == -1 || ph == 2)), "R9 ack",
          32'(req_ack), 32'(req_valid && (ph == -1 || ph == 2)));
      if (ph >= 0) since++;
      if (ph == 2) chk(since == 3, cur_wr ? "R3 write length" : "R2 read length", 32'(since), 3);
      rd_pend = (ph == 2 && !cur_wr);
      rd_exp  = cur_rd;
      take = req_valid && req_ack;
      if (ph == -1 || ph == 2) begin
        if (take) begin
          ph = 0; since = 0;
          cur_wr = req_write; cur_addr = req_addr; cur_data = req_wdata;
          cur_rd = ref_mem[req_addr[7:0]];
          if (req_write) ref_mem[req_addr[7:0]] = req_wdata;
        end else ph = -1;
      end else ph = ph + 1;
    end
  end

  // Called just after a rising edge; returns just after the accepting edge.
  task automatic access(bit wr, logic [15:0] a, logic [7:0] d, int gap);
    req_valid = 1; req_write = wr; req_addr = a; req_wdata = d;
    forever begin
      @(negedge clk);
      if (req_ack) break;
    end
    @(posedge clk); #2;
    req_valid = 0;
    repeat (gap) begin @(posedge clk); #2; end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1; checks++; errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    rst_n = 0; req_valid = 0; req_write = 0; req_addr = '0; req_wdata = '0;
    repeat (3) @(posedge clk);
    #2 rst_n = 1;
    @(posedge clk); #2;
    // R10: idle state after reset
    chk(mem_ce_n && mem_rw && !mem_wdata_oe && !rd_valid, "R10 idle after reset",
        {mem_ce_n, mem_rw, mem_wdata_oe, rd_valid}, 4'b1100);
    // Directed: isolated write, then read back (R3, R2, R7)
    access(1, 16'hA005, 8'h5E, 3);
    access(0, 16'hA005, 8'h00, 3);
    // Back-to-back writes and reads with no gap (R9)
    access(1, 16'hFF10, 8'h81, 0);
    access(1, 16'h0011, 8'h7E, 0);
    access(0, 16'hFF10, 8'h00, 0);
    access(0, 16'h0011, 8'h00, 0);
    access(0, 16'h1234, 8'h00, 2);
    // Write then immediate read of the same byte (R6, R7)
    access(1, 16'h0042, 8'hC3, 0);
    access(0, 16'h0042, 8'h00, 2);
    // Reset in the middle of a write (R10)
    access(1, 16'h0050, 8'h99, 0);
    @(posedge clk); @(posedge clk); #2;
    rst_n = 0;
    repeat (2) @(posedge clk);
    #2 rst_n = 1;
    @(posedge clk); #2;
    access(0, 16'h0050, 8'h00, 1);
    // Constrained random traffic over a small address window
    for (int n = 0; n < 400; n++) begin
      logic [15:0] a;
      a = {4'($urandom), 8'h0, 4'($urandom)};
      access(1'($urandom), a, 8'($urandom), int'($urandom % 3));
    end
    repeat (5) @(posedge clk);
    if (!done) begin
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule